// File: doc/BRIEF.md
# Multi-Channel Output Compare Timer

This block is a timebase with five compare channels. A 16-bit counter runs freely from reset and advances once per prescale period; the period is chosen by a 2-bit code. Each channel holds a 16-bit compare value. When the counter takes on that value, the channel raises its status flag and updates its output pin. The update follows a 2-bit action setting: leave the pin, toggle it, drive it low or drive it high.

Software reaches the block through a flat register bus. Each write carries a full 16-bit word in one cycle, and reads are combinational. Software can force a channel's pin action at any time without waiting for a match. Each flag is cleared by writing a one to its bit. A single interrupt line combines the flags that software has enabled. The prescale code is a one-time setting: only the first write is accepted, and only within a short window after reset.

Top module: `cmpt_top`

## Requirements
- R1: After reset the counter reads 0 at address 0. It then increments by one at the end of every prescale period and wraps from 0xFFFF to 0x0000.
- R2: A bus write to address 0 leaves the counter value unchanged.
- R3: The prescale code at address 1, bits [1:0], selects the period: 00 → 1 cycle, 01 → 4 cycles, 10 → 8 cycles, 11 → 16 cycles. Its reset value is 00.
- R4: The prescale code accepts only its first write, and only if that write occurs within the first 64 clock cycles after reset. Every other write to it is ignored.
- R5: The overflow flag (address 5, bit 5, also on `ovf_flag`) sets on the clock edge where the counter wraps from 0xFFFF to 0x0000.
- R6: Channel i's compare value is written at address 8+i. Its flag (address 5, bit i) sets on the clock edge where the counter becomes equal to that value.
- R7: The action register at address 2 holds bits [2i+1:2i] for channel i: 00 none, 01 toggle, 10 drive low, 11 drive high. The action is applied to `cmp_pin[i]` on the same edge the flag sets.
- R8: Writing 1 to bit i at address 3 applies channel i's action on that write's edge. The flag is not set. Address 3 reads as 0.
- R9: Writing 1 to a flag bit at address 5 clears that flag. Writing 0 leaves it unchanged. A set event in the same cycle wins over a clear.
- R10: The enable register at address 4 holds bits [4:0] for the channel flags and bit 5 for the overflow flag. `irq` is high when any flag is high together with its enable bit.
- R11: After reset all pins, flags, enables, actions and compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| cmp_pin | output | 5 | Channel output pins |
| cmp_flag | output | 5 | Channel match flags |
| ovf_flag | output | 1 | Counter overflow flag |
| irq | output | 1 | Combined enabled-flag interrupt |

## Verification
The hardest condition to reach from the ports is the counter wrap. Because the counter cannot be written, the overflow flag (and the flood of matches from stale compare values) only appears after a full 65536-cycle lap. The bench reads the counter and waits exactly the remaining number of cycles. It then samples the overflow flag one cycle before the wrap edge and again on it.

The match edge is checked the same way. The bench arms a compare value a random distance ahead of the current count and samples the flag and pin in both the cycle before and the cycle of the match. The one-time prescale window needs two reset sessions: one with an early write followed by a second early write, and one with only a late write.

// File: rtl/cmpt_pkg.sv
// Shared types and helpers for the compare timer.
// Assumes: action codes are 2 bits per channel.
package cmpt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } act_e;

    // Register addresses (compare channels start at CMP_BASE)
    localparam int unsigned A_COUNT = 0;
    localparam int unsigned A_PRESC = 1;
    localparam int unsigned A_ACT   = 2;
    localparam int unsigned A_FORCE = 3;
    localparam int unsigned A_EN    = 4;
    localparam int unsigned A_FLAGS = 5;
    localparam int unsigned CMP_BASE = 8;

    // Next pin level for a given action
    function automatic logic pin_next(input act_e a, input logic cur);
        case (a)
            ACT_TOG:  return ~cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/cmpt_prescale.sv
// Prescaler with a write-once code that locks after a window.
// Produces a single-cycle tick every 1, 4, 8 or 16 cycles.
// Assumes: wr_i is a one-cycle strobe; code changes restart nothing.
module cmpt_prescale #(
    parameter int unsigned WIN_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] code_i,
    output logic [1:0] code_o,
    output logic       tick_o
);
    localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);

    logic [WIN_W-1:0] win_q;
    logic             taken_q;
    logic             locked;
    logic [1:0]       code_q;
    logic [3:0]       div_q;
    logic [3:0]       limit;

    assign locked = taken_q || (win_q == WIN_W'(WIN_CYC));

    // Count cycles since reset, saturating at the window length
    always_ff @(posedge clk) begin
        if (!rst_n)              win_q <= '0;
        else if (!(win_q == WIN_W'(WIN_CYC))) win_q <= win_q + 1'b1;
    end

    // Accept only the first code write inside the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= 2'b00;
            taken_q <= 1'b0;
        end else if (wr_i && !locked) begin
            code_q  <= code_i;
            taken_q <= 1'b1;
        end
    end

    // Map code to terminal count of the divider
    always_comb begin
        case (code_q)
            2'b00:   limit = 4'd0;
            2'b01:   limit = 4'd3;
            2'b10:   limit = 4'd7;
            default: limit = 4'd15;
        endcase
    end

    assign tick_o = (div_q >= limit);

    // Divider counter
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    assign code_o = code_q;

    AST_CODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(code_q)); // R4

endmodule

// File: rtl/cmpt_counter.sv
// Free-running counter that advances on each prescale tick.
// Provides the incremented value and a wrap pulse.
// Assumes: tick_i is a single-cycle pulse.
module cmpt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_next_o = cnt_q + 1'b1;
    assign wrap_o     = tick_i && (cnt_q == {CNT_W{1'b1}});
    assign cnt_o      = cnt_q;

    // Advance on tick; no bus write path exists
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_next_o;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/cmpt_channel.sv
// One compare channel: compare register, match flag and output pin.
// A match is the edge where the counter becomes equal to the compare
// value. A force strobe applies the action without touching the flag.
// Assumes: clr_i and force_i are one-cycle strobes from the bus decode.
module cmpt_channel #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [1:0]       act_i,
    input  logic             force_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             flag_o,
    output logic             pin_o
);
    import cmpt_pkg::*;

    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;
    logic             pin_q;
    logic             hit;
    logic             fire;

    assign hit  = tick_i && (cnt_next_i == cmp_q);
    assign fire = hit || force_i;

    // Full-word compare register load
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (cmp_we_i) cmp_q <= cmp_wdata_i;
    end

    // Flag: set on match, cleared by write-one, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    // Pin update on match or force
    always_ff @(posedge clk) begin
        if (!rst_n)    pin_q <= 1'b0;
        else if (fire) pin_q <= pin_next(act_e'(act_i), pin_q);
    end

    assign cmp_o  = cmp_q;
    assign flag_o = flag_q;
    assign pin_o  = pin_q;

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q); // R6
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !hit && !flag_q) |=> !flag_q); // R8
    AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_i == 2'b10) |=> !pin_q); // R7
    AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && act_i == 2'b11) |=> pin_q); // R7
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_q); // R9

endmodule

// File: rtl/cmpt_top.sv
// Output compare timer top: bus decode, enables, overflow flag,
// interrupt combine and read mux around the counter and channels.
// Assumes: one bus access per cycle, reads are combinational.
module cmpt_top #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned NUM_CH  = 5,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned WIN_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] cmp_pin,
    output logic [NUM_CH-1:0] cmp_flag,
    output logic              ovf_flag,
    output logic              irq
);
    import cmpt_pkg::*;

    localparam int unsigned ACT_W  = 2 * NUM_CH;
    localparam int unsigned FLAG_W = NUM_CH + 1;

    logic              tick;
    logic [1:0]        code;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_next;
    logic              wrap;
    logic [ACT_W-1:0]  act_q;
    logic [FLAG_W-1:0] en_q;
    logic              ovf_q;
    logic [NUM_CH-1:0] force_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] cmp_we;
    logic [CNT_W-1:0]  cmp_val [NUM_CH];
    logic [FLAG_W-1:0] flags;

    logic wr_presc, wr_act, wr_en, wr_force, wr_flags;
    assign wr_presc = bus_wr && (bus_addr == ADDR_W'(A_PRESC));
    assign wr_act   = bus_wr && (bus_addr == ADDR_W'(A_ACT));
    assign wr_en    = bus_wr && (bus_addr == ADDR_W'(A_EN));
    assign wr_force = bus_wr && (bus_addr == ADDR_W'(A_FORCE));
    assign wr_flags = bus_wr && (bus_addr == ADDR_W'(A_FLAGS));

    assign force_v = wr_force ? bus_wdata[NUM_CH-1:0] : '0;
    assign clr_v   = wr_flags ? bus_wdata[NUM_CH-1:0] : '0;

    cmpt_prescale #(.WIN_CYC(WIN_CYC)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_presc),
        .code_i (bus_wdata[1:0]),
        .code_o (code),
        .tick_o (tick)
    );

    cmpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next),
        .wrap_o     (wrap)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign cmp_we[i] = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + i));
        cmpt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmp_we_i    (cmp_we[i]),
            .cmp_wdata_i (bus_wdata),
            .tick_i      (tick),
            .cnt_next_i  (cnt_next),
            .act_i       (act_q[2*i +: 2]),
            .force_i     (force_v[i]),
            .clr_i       (clr_v[i]),
            .cmp_o       (cmp_val[i]),
            .flag_o      (cmp_flag[i]),
            .pin_o       (cmp_pin[i])
        );
    end

    // Action and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            en_q  <= '0;
        end else begin
            if (wr_act) act_q <= bus_wdata[ACT_W-1:0];
            if (wr_en)  en_q  <= bus_wdata[FLAG_W-1:0];
        end
    end

    // Overflow flag: set on wrap, write-one clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                        ovf_q <= 1'b0;
        else if (wrap)                     ovf_q <= 1'b1;
        else if (wr_flags && bus_wdata[NUM_CH]) ovf_q <= 1'b0;
    end

    assign ovf_flag = ovf_q;
    assign flags    = {ovf_q, cmp_flag};
    assign irq      = |(flags & en_q);

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_COUNT): bus_rdata = cnt;
            ADDR_W'(A_PRESC): bus_rdata = CNT_W'(code);
            ADDR_W'(A_ACT):   bus_rdata = CNT_W'(act_q);
            ADDR_W'(A_EN):    bus_rdata = CNT_W'(en_q);
            ADDR_W'(A_FLAGS): bus_rdata = CNT_W'(flags);
            default: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (bus_addr == ADDR_W'(CMP_BASE + i)) bus_rdata = cmp_val[i];
            end
        endcase
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q); // R5
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq); // R10

endmodule

// File: tb/test_cmpt_top.sv
module test_cmpt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  cmp_pin;
    logic [4:0]  cmp_flag;
    logic        ovf_flag;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic [4:0] exp_pin = '0;
    logic [9:0] act_sh = '0;

    cmpt_top i_cmpt_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_pin(cmp_pin),
        .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic next_pin(input logic [1:0] a, input logic cur);
        case (a)
            2'b01: return ~cur;
            2'b10: return 1'b0;
            2'b11: return 1'b1;
            default: return cur;
        endcase
    endfunction

    // Arm channel ch a distance d ahead and check flag/pin around the match edge
    task automatic arm(input int ch, input logic [1:0] a, input int d, input bit clr);
        logic [15:0] v;
        act_sh[2*ch +: 2] = a;
        wr(4'd2, {6'd0, act_sh});
        if (clr) wr(4'd5, 16'h003F);
        rd(4'd0, v);
        bus_wr = 1'b1; bus_addr = 4'(8 + ch); bus_wdata = v + 16'(d);
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (d - 2) @(negedge clk);
        #1;
        chk("R6 no flag before match", 32'(cmp_flag[ch]), 32'd0);
        chk("R7 pin before match", 32'(cmp_pin[ch]), 32'(exp_pin[ch]));
        @(negedge clk);
        #1;
        exp_pin[ch] = next_pin(a, exp_pin[ch]);
        chk("R6 flag on match", 32'(cmp_flag[ch]), 32'd1);
        chk("R7 pin on match", 32'(cmp_pin[ch]), 32'(exp_pin[ch]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v0, v1;
        int seed;
        seed = $urandom(32'h1357);

        // Session 1: prescale once-only
        do_reset();
        #1;
        chk("R11 reset pins", 32'(cmp_pin), 0);
        chk("R11 reset flags", 32'({ovf_flag, cmp_flag}), 0);
        chk("R11 reset irq", 32'(irq), 0);
        rd(4'd0, v0);
        chk("R1 counter small after reset", 32'(v0 < 16'd4), 1);
        wr(4'd1, 16'h0002);
        wr(4'd1, 16'h0003);
        rd(4'd1, v0);
        chk("R4 first write kept", 32'(v0), 2);
        rd(4'd0, v0);
        repeat (79) @(negedge clk);
        rd(4'd0, v1);
        chk("R3 divide by 8", 32'(v1 - v0), 10);
        repeat (40) @(negedge clk);
        wr(4'd1, 16'h0000);
        rd(4'd0, v0);
        repeat (79) @(negedge clk);
        rd(4'd0, v1);
        chk("R4 late write ignored rate", 32'(v1 - v0), 10);

        // Session 2: default divide by 1
        do_reset();
        exp_pin = '0; act_sh = '0;
        rd(4'd2, v0);
        chk("R11 reset actions", 32'(v0), 0);
        rd(4'd8, v0);
        chk("R11 reset compare", 32'(v0), 0);
        repeat (70) @(negedge clk);
        wr(4'd1, 16'h0003);
        rd(4'd1, v0);
        chk("R4 write after window ignored", 32'(v0), 0);
        rd(4'd0, v0);
        repeat (79) @(negedge clk);
        rd(4'd0, v1);
        chk("R3 divide by 1", 32'(v1 - v0), 80);
        rd(4'd0, v0);
        wr(4'd0, 16'h1234);
        rd(4'd0, v1);
        chk("R2 counter write ignored", 32'(v1), 32'(v0 + 16'd3));

        // Directed compare actions
        arm(0, 2'b11, 12, 1'b1);
        arm(0, 2'b10, 9, 1'b1);
        arm(1, 2'b01, 15, 1'b1);
        arm(3, 2'b00, 10, 1'b0);
        // W1C: ch1 and ch3 set
        wr(4'd5, 16'h0000);
        #1 chk("R9 write zero keeps", 32'(cmp_flag), 32'h0A);
        wr(4'd5, 16'h0002);
        #1 chk("R9 write one clears only its bit", 32'(cmp_flag), 32'h08);
        wr(4'd4, 16'h0008);
        #1 chk("R10 irq from enabled flag", 32'(irq), 1);
        wr(4'd4, 16'h0017);
        #1 chk("R10 irq masked", 32'(irq), 0);

        // Force
        wr(4'd5, 16'h003F);
        act_sh[5:4] = 2'b01;
        wr(4'd2, {6'd0, act_sh});
        wr(4'd3, 16'h0004);
        exp_pin[2] = ~exp_pin[2];
        #1;
        chk("R8 force toggles pin", 32'(cmp_pin[2]), 32'(exp_pin[2]));
        chk("R8 force leaves flag", 32'(cmp_flag[2]), 0);
        rd(4'd3, v0);
        chk("R8 force reads zero", 32'(v0), 0);
        act_sh[9:8] = 2'b00;
        wr(4'd2, {6'd0, act_sh});
        wr(4'd3, 16'h0010);
        #1 chk("R8 force with no action", 32'(cmp_pin[4]), 32'(exp_pin[4]));

        // Random compare runs
        for (int k = 0; k < 20; k++) begin
            int ch;
            logic [1:0] a;
            logic [5:0] en;
            ch = int'($urandom % 5);
            a  = 2'($urandom);
            en = 6'($urandom);
            wr(4'd4, {10'd0, en});
            arm(ch, a, 6 + int'($urandom % 40), 1'b1);
            chk("R10 irq after match", 32'(irq), 32'(en[ch]));
        end

        // Overflow
        wr(4'd4, 16'h0020);
        wr(4'd5, 16'h003F);
        rd(4'd0, v0);
        repeat (65536 - int'(v0) - 1) @(negedge clk);
        #1 chk("R5 no overflow before wrap", 32'(ovf_flag), 0);
        @(negedge clk);
        #1 chk("R5 overflow on wrap", 32'(ovf_flag), 1);
        chk("R10 irq from overflow", 32'(irq), 1);
        rd(4'd0, v1);
        chk("R1 wrapped counter", 32'(v1), 1);
        wr(4'd5, 16'h0020);
        #1 chk("R9 overflow cleared", 32'(ovf_flag), 0);
        chk("R10 irq drops", 32'(irq), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule